// File: doc/BRIEF.md
# Sticky Event Flags with Masked Interrupt

This block collects asynchronous events into sticky flag bits and raises one interrupt line when any flag whose mask bit allows it is set. It watches four general-purpose pins and records each rising transition and each falling transition in its own flag. A pin's direction makes no difference: the block only sees the sampled level, so transitions that the chip drives itself are logged just like transitions that arrive from outside. A day-alarm comparator checks a programmable 20-bit seconds value against a 20-bit running seconds count. A single-cycle conversion-ready pulse sets one more flag.

Software uses a small register port. Reading the status register returns all flags and clears them in the same operation. A mask register selects which flags may assert the interrupt. The alarm value and the alarm enable have their own registers. The seconds counter, the pin drivers and the serial transport sit outside this block.

Top module: `evtStatusUnit`

## Requirements
- R1: With the alarm enable set, status bit 0 (alarm) is set at the clock edge where the alarm register (address 2, bits [19:0]) first equals `secCount`. The flag is set only when the compare changes from unequal to equal. With the enable clear it is never set.
- R2: Writing address 3 with bit 0 = 0 turns the alarm enable off and clears status bit 0 at that edge. An alarm match arising at the same edge still sets the flag.
- R3: A low-to-high change on `pinIn[i]` sets status bit 2+i at the third rising clock edge after the change. The change passes through a two-flop synchroniser. The flag stays set until it is cleared.
- R4: A high-to-low change on `pinIn[i]` sets status bit 6+i with the same timing as R3.
- R5: A read of address 0 places the flag vector, as it stood before that edge, on `rdData[9:0]` (upper bits zero) one cycle later. The same edge clears every flag.
- R6: When an event arrives at the same edge as a clearing status read, its flag ends up set. The read returns the value from before the event.
- R7: `irqOut` is high exactly when some flag bit is 1 and its mask bit (address 1, bits [9:0]) is 0. A mask value of 1 blocks that flag.
- R8: After reset all flags are 0, `irqOut` is 0, the alarm value and alarm enable are 0, and the mask is 0x3FD. In that mask only the conversion-ready flag is unmasked.
- R9: A high `readyEvt` for one cycle sets status bit 1.
- R10: Reads of addresses 1, 2 and 3 return the mask, the alarm value and the enable (bit 0) one cycle later, and they leave the flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 status, 1 mask, 2 alarm, 3 control |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| pinIn | input | 4 | Sampled pin levels |
| secCount | input | 20 | Running seconds count |
| readyEvt | input | 1 | Conversion-ready event pulse |
| irqOut | output | 1 | Active-high interrupt |

## Verification
Any flag that is wrongly set or cleared appears on `irqOut` at the edge right after the fault when that flag is unmasked, and it appears in full on the next status read. The bench therefore compares the interrupt on every cycle and compares each read against a reference model. A synchroniser that is off by one stage moves the interrupt by one cycle, so cycle-exact checking catches it. Losing an event to a clearing read shows up as a missing bit in the read that follows.

// File: rtl/evtPkg.sv
package evtPkg;
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_ALARM  = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  typedef struct packed {
    logic       rdAny;
    logic [1:0] rdAddr;
    logic       statusRd;
    logic       maskWr;
    logic       alarmWr;
    logic       ctrlWr;
  } strobeT;
endpackage

// File: rtl/evtCtrl.sv
module evtCtrl
  import evtPkg::*;
(
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  output strobeT     strb
);
  always_comb begin
    strb          = '0;
    strb.rdAny    = rdEn;
    strb.rdAddr   = addr;
    strb.statusRd = rdEn && (addr == ADDR_STATUS);
    strb.maskWr   = wrEn && (addr == ADDR_MASK);
    strb.alarmWr  = wrEn && (addr == ADDR_ALARM);
    strb.ctrlWr   = wrEn && (addr == ADDR_CTRL);
  end
endmodule

// File: rtl/pinEdgeSync.sv
module pinEdgeSync (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  output logic riseEvt,
  output logic fallEvt
);
  logic syncA, syncB, prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign riseEvt = syncB & ~prevQ;
  assign fallEvt = ~syncB & prevQ;
endmodule

// File: rtl/evtDatapath.sv
module evtDatapath
  import evtPkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int SEC_W    = 20,
  parameter int DATA_W   = 32,
  localparam int FLAG_W  = 2 + 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [SEC_W-1:0]    secCount,
  input  logic                readyEvt,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);
  localparam logic [FLAG_W-1:0] MASK_RESET = {{(FLAG_W-2){1'b1}}, 2'b01};

  logic [FLAG_W-1:0]   flagQ, maskQ, setVec, flagNext;
  logic [NUM_PINS-1:0] riseVec, fallVec;
  logic [SEC_W-1:0]    alarmSecQ;
  logic                alarmEnQ, matchPrevQ, matchNow, alarmHit, alarmOff;
  logic                unusedWr;

  assign unusedWr = ^wrData[DATA_W-1:SEC_W];

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    pinEdgeSync uSync (
      .clk    (clk),
      .rstN   (rstN),
      .pinRaw (pinIn[g]),
      .riseEvt(riseVec[g]),
      .fallEvt(fallVec[g])
    );
  end

  assign matchNow = alarmEnQ && (alarmSecQ == secCount);
  assign alarmHit = matchNow && !matchPrevQ;
  assign alarmOff = strb.ctrlWr && !wrData[0];
  assign setVec   = {fallVec, riseVec, readyEvt, alarmHit};

  always_comb begin
    flagNext = flagQ;
    if (strb.statusRd) flagNext = '0;
    if (alarmOff)      flagNext[0] = 1'b0;
    flagNext = flagNext | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ      <= '0;
      maskQ      <= MASK_RESET;
      alarmSecQ  <= '0;
      alarmEnQ   <= 1'b0;
      matchPrevQ <= 1'b0;
      rdData     <= '0;
    end else begin
      flagQ      <= flagNext;
      matchPrevQ <= matchNow;
      if (strb.maskWr)  maskQ     <= wrData[FLAG_W-1:0];
      if (strb.alarmWr) alarmSecQ <= wrData[SEC_W-1:0];
      if (strb.ctrlWr)  alarmEnQ  <= wrData[0];
      if (strb.rdAny) begin
        unique case (strb.rdAddr)
          ADDR_STATUS: rdData <= DATA_W'(flagQ);
          ADDR_MASK:   rdData <= DATA_W'(maskQ);
          ADDR_ALARM:  rdData <= DATA_W'(alarmSecQ);
          default:     rdData <= DATA_W'(alarmEnQ);
        endcase
      end
    end
  end

  assign irqOut = |(flagQ & ~maskQ);

  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> flagQ[0]); // R1
  AST_ALARM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (alarmOff && !alarmHit) |=> !flagQ[0]); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.statusRd && !alarmOff) |=> ((flagQ & $past(flagQ)) == $past(flagQ))); // R3
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && setVec == '0) |=> (flagQ == '0)); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((flagQ & $past(setVec)) == $past(setVec))); // R6
endmodule

// File: rtl/evtStatusUnit.sv
module evtStatusUnit
  import evtPkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int SEC_W    = 20,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [SEC_W-1:0]    secCount,
  input  logic                readyEvt,
  output logic                irqOut
);
  strobeT strb;

  evtCtrl uCtrl (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .strb(strb)
  );

  evtDatapath #(
    .NUM_PINS(NUM_PINS),
    .SEC_W   (SEC_W),
    .DATA_W  (DATA_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .secCount(secCount),
    .readyEvt(readyEvt),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

  AST_IRQ_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqOut); // R8
endmodule

// File: tb/evtStatusUnit_test.sv
`timescale 1ns/1ps
module evtStatusUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  pinIn = '0;
  logic [19:0] secCount = '0;
  logic        readyEvt = 1'b0;
  logic        irqOut;

  int compared = 0, mismatched = 0;

  logic [3:0]  pinV = '0;
  logic [19:0] secV = '0;
  logic        rdyV = 1'b0;

  logic [3:0]  m1 = '0, m2 = '0, m3 = '0;
  logic [9:0]  mFlags = '0, mMask = 10'h3FD;
  logic [19:0] mAlarm = '0;
  logic        mEn = 1'b0, mMatchPrev = 1'b0;

  always #2.5 clk = ~clk;

  evtStatusUnit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .secCount(secCount),
    .readyEvt(readyEvt), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] readValue(input logic [1:0] a);
    case (a)
      2'd0:    return {22'd0, mFlags};
      2'd1:    return {22'd0, mMask};
      2'd2:    return {12'd0, mAlarm};
      default: return {31'd0, mEn};
    endcase
  endfunction

  function automatic logic [9:0] irqMask(input logic [9:0] f, input logic [9:0] m);
    return f & ~m;
  endfunction

  task automatic cycle(input logic doWr, input logic doRd, input logic [1:0] a,
                       input logic [31:0] wd, input string req);
    logic        matchNow;
    logic [9:0]  setV, nf;
    logic [31:0] expRd;
    @(negedge clk);
    wrEn = doWr; rdEn = doRd; addr = a; wrData = wd;
    pinIn = pinV; secCount = secV; readyEvt = rdyV;
    matchNow = mEn && (mAlarm == secV);
    setV = {~m2 & m3, m2 & ~m3, rdyV, matchNow & ~mMatchPrev};
    expRd = readValue(a);
    nf = mFlags;
    if (doRd && a == 2'd0) nf = '0;
    if (doWr && a == 2'd3 && !wd[0]) nf[0] = 1'b0;
    nf = nf | setV;
    mFlags = nf;
    mMatchPrev = matchNow;
    if (doWr && a == 2'd1) mMask = wd[9:0];
    if (doWr && a == 2'd2) mAlarm = wd[19:0];
    if (doWr && a == 2'd3) mEn = wd[0];
    m3 = m2; m2 = m1; m1 = pinV;
    @(posedge clk);
    #1;
    check({req, "/R7 irq"}, {31'd0, irqOut}, {31'd0, |irqMask(mFlags, mMask)});
    if (doRd) check({req, " read"}, rdData, expRd);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 2'd0, 32'd0, req);
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1 check("R8 irq after reset", {31'd0, irqOut}, 32'd0);
    cycle(1'b0, 1'b1, 2'd1, 32'd0, "R8 mask reset");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R8 status reset");
    cycle(1'b0, 1'b1, 2'd2, 32'd0, "R8 alarm reset");
    cycle(1'b0, 1'b1, 2'd3, 32'd0, "R8 enable reset");

    // R9: conversion-ready pulse, unmasked at reset
    rdyV = 1'b1; cycle(1'b0, 1'b0, 2'd0, 32'd0, "R9 ready");
    rdyV = 1'b0; idle(1, "R9 hold");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R9/R5 read status");
    idle(1, "R5 cleared");

    // R7 masked pin event gives no irq
    pinV = 4'b0001; idle(4, "R7 masked rise");
    cycle(1'b1, 1'b0, 2'd1, 32'd0, "R7 unmask all");
    cycle(1'b0, 1'b1, 2'd1, 32'd0, "R10 mask read");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R3 rise pin0");

    // R3 / R4 timing per pin
    pinV = 4'b0100; idle(2, "R3 before third edge");
    idle(2, "R3/R4 after third edge");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R3 R4 read");
    pinV = 4'b0000; idle(4, "R4 fall");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R4 read");

    // R1 alarm
    secV = 20'd99;
    cycle(1'b1, 1'b0, 2'd2, 32'd100, "R1 set alarm");
    cycle(1'b1, 1'b0, 2'd3, 32'd1, "R1 enable");
    cycle(1'b0, 1'b1, 2'd2, 32'd0, "R10 alarm read");
    secV = 20'd100; idle(3, "R1 match");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R1 read");
    idle(2, "R1 no retrigger");

    // R2 alarm off clears
    secV = 20'd101; idle(1, "R2 leave");
    secV = 20'd100; idle(1, "R2 rematch");
    cycle(1'b1, 1'b0, 2'd3, 32'd0, "R2 disable");
    cycle(1'b0, 1'b1, 2'd3, 32'd0, "R10 enable read");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R2 read");
    secV = 20'd5; idle(1, "R1 disabled");
    secV = 20'd100; idle(2, "R1 disabled no set");

    // R6 event coincides with clearing read
    pinV = 4'b0010; idle(2, "R6 setup");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R6 read at event");
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R6 flag kept");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  op;
      logic [31:0] wd;
      op = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) pinV = 4'($urandom);
      if ($urandom_range(0, 7) == 0) secV = 20'($urandom_range(0, 3));
      rdyV = ($urandom_range(0, 9) == 0);
      wd = $urandom;
      case (op)
        4'd0, 4'd1, 4'd2: cycle(1'b0, 1'b1, 2'd0, wd, "R5 rnd status");
        4'd3: cycle(1'b1, 1'b0, 2'd1, wd, "R7 rnd mask");
        4'd4: cycle(1'b1, 1'b0, 2'd2, {12'd0, 20'($urandom_range(0, 3))}, "R1 rnd alarm");
        4'd5: cycle(1'b1, 1'b0, 2'd3, wd, "R2 rnd ctrl");
        4'd6: cycle(1'b0, 1'b1, 2'(op), wd, "R10 rnd read");
        4'd7: cycle(1'b1, 1'b1, 2'd0, wd, "R6 rnd read");
        default: cycle(1'b0, 1'b0, 2'd0, wd, "R3 rnd idle");
      endcase
    end
    rdyV = 1'b0;
    cycle(1'b0, 1'b1, 2'd0, 32'd0, "R5 final read");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule